// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a four-bank, 16-bit single-data-rate SDRAM from reset until the memory is able to take ordinary traffic. After reset is released it holds clock-enable and the byte masks high. It drives only NOP for a long settling interval. It then closes every bank with one all-bank PRECHARGE, issues a series of AUTO REFRESH commands and writes the mode register once. Each command is followed by a parameterised idle gap.

When the gap after the mode write has run out, `init_done` rises and stays high. From then on the sequencer drives NOP until the next reset, and the surrounding controller hands the command bus to its normal access path. The clock period, the settling time, the precharge and refresh recovery times (in nanoseconds) and the mode-write gap (in clocks) are parameters. The block converts the times to cycles by rounding up. Every pin comes from a flop that updates on the rising clock edge.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs show command inhibit (`sdr_cs_n`=1), `init_done`=0, and clock-enable and all mask bits high.
- R2: `sdr_cke` and every bit of `sdr_dqm` are 1 in every cycle.
- R3: For the first W = ceil(WAIT_NS*1000/CLK_PERIOD_PS) clock edges after reset is released, the command {cs_n,ras_n,cas_n,we_n} is NOP = 0111. No other command appears in that window.
- R4: On edge W+1 after release, exactly one PRECHARGE (0010) appears, with address bit 10 = 1 (all banks) and bank address 00.
- R5: Exactly N = max(REFRESH_COUNT, 8) AUTO REFRESH commands (0001) follow. The first comes TRP cycles after the precharge and each later one TRFC cycles after the one before it. TRP and TRFC are ceil(time_ns*1000/CLK_PERIOD_PS), with a minimum of 1.
- R6: One LOAD MODE REGISTER command (0000) comes TRFC cycles after the last refresh. It carries `MODE_WORD` on the address pins and bank address 00. It never appears earlier or a second time.
- R7: `init_done` rises exactly TMRD_CYC cycles after the mode-register command and stays high until reset.
- R8: Every cycle not named in R4 to R6 carries NOP, including all cycles after `init_done` rises.
- R9: Asserting reset at any point of the sequence, including during the wait or between refreshes, restarts the sequence from the beginning of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Synchronous active-low reset |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_cke | output | 1 | Clock enable, held high |
| sdr_dqm | output | DQ_WIDTH/8 | Byte masks, held high |
| sdr_ba | output | 2 | Bank address |
| sdr_addr | output | ROW_BITS | Address pins |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench decodes the command bus on every cycle and compares it with a schedule computed from the parameters. Off-by-one errors in the wait counter or in any recovery gap therefore show up as a command one cycle early or late. A refresh loop that stops at seven, or runs past the count, moves the mode-register command and is reported there. A precharge without the all-bank address bit, or a mode write with the wrong word, fails the address checks. Reset is also applied in the middle of the wait and between refreshes. A design that keeps counter or state values through reset would then skip or shorten the next sequence.

// File: rtl/pwrup_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes command bits are ordered {cs_n, ras_n, cas_n, we_n}.
package pwrup_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_REF,
        ST_LMR,
        ST_HOLD,
        ST_IDLE
    } init_step_e;

    // Converts a time in picoseconds to whole clock cycles, rounding up, minimum 1.
    function automatic int ps_to_cycles(input int t_ps, input int period_ps);
        int c;
        c = (t_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pwrup_timer.sv
// Loadable down counter used for every wait of the power-up sequence.
// Counts down to zero and holds there. A load takes priority over counting.
// Assumes RESET_VAL fits in WIDTH bits.
module pwrup_timer #(
    parameter int WIDTH = 16,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic             zero_o
);

    logic [WIDTH-1:0] cnt_q;

    // Counter: reload on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R5
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/pwrup_ctrl.sv
// Step controller of the power-up sequence.
// Each issuing step waits for the shared timer to reach zero, emits its command
// for one cycle, reloads the timer with its recovery gap minus one and moves on.
// Assumes the timer it drives reports zero in the cycle after its count runs out.
module pwrup_ctrl
    import pwrup_pkg::*;
#(
    parameter int TW     = 16,
    parameter int REF_N  = 8,
    parameter int TRP_C  = 5,
    parameter int TRFC_C = 17,
    parameter int TMRD_C = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_i,
    output logic          load_o,
    output logic [TW-1:0] load_val_o,
    output sdr_cmd_e      cmd_o,
    output logic          done_o
);

    localparam int RW = $clog2(REF_N + 1);

    init_step_e    step_q, step_d;
    logic [RW-1:0] ref_left_q;
    logic          ref_dec;
    logic          set_done;

    // Next step, command and timer reload for the current step.
    always_comb begin
        step_d     = step_q;
        cmd_o      = CMD_NOP;
        load_o     = 1'b0;
        load_val_o = '0;
        ref_dec    = 1'b0;
        set_done   = 1'b0;
        case (step_q)
            ST_WAIT: if (zero_i) step_d = ST_PRE;
            ST_PRE: if (zero_i) begin
                cmd_o      = CMD_PRE;
                load_o     = 1'b1;
                load_val_o = TW'(TRP_C - 1);
                step_d     = ST_REF;
            end
            ST_REF: if (zero_i) begin
                cmd_o      = CMD_REF;
                load_o     = 1'b1;
                load_val_o = TW'(TRFC_C - 1);
                ref_dec    = 1'b1;
                if (ref_left_q == RW'(1)) step_d = ST_LMR;
            end
            ST_LMR: if (zero_i) begin
                cmd_o      = CMD_LMR;
                load_o     = 1'b1;
                load_val_o = TW'(TMRD_C - 1);
                step_d     = ST_HOLD;
            end
            ST_HOLD: if (zero_i) begin
                set_done = 1'b1;
                step_d   = ST_IDLE;
            end
            default: step_d = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_WAIT;
        else        step_q <= step_d;
    end

    // Remaining auto-refresh count.
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_left_q <= RW'(REF_N);
        else if (ref_dec) ref_left_q <= ref_left_q - 1'b1;
    end

    // Sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_o <= 1'b0;
        else if (set_done) done_o <= 1'b1;
    end

    // R5
    ref_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_REF) |-> (ref_left_q != '0));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

endmodule

// File: rtl/pwrup_cmd_out.sv
// Output stage: registers the chosen command and the address and bank that go with it.
// The precharge sets the all-bank bit, the mode write carries the mode word and
// every other command drives zero on the address pins.
// Assumes AP_BIT < ROW_BITS.
module pwrup_cmd_out
    import pwrup_pkg::*;
#(
    parameter int ROW_BITS = 13,
    parameter int AP_BIT   = 10,
    parameter int DQM_W    = 2,
    parameter logic [ROW_BITS-1:0] MODE_WORD = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sdr_cmd_e            cmd_i,
    output logic                cs_n_o,
    output logic                ras_n_o,
    output logic                cas_n_o,
    output logic                we_n_o,
    output logic                cke_o,
    output logic [DQM_W-1:0]    dqm_o,
    output logic [1:0]          ba_o,
    output logic [ROW_BITS-1:0] addr_o
);

    localparam logic [ROW_BITS-1:0] AP_MASK = ROW_BITS'(1) << AP_BIT;

    logic [ROW_BITS-1:0] addr_d;

    // Address pins for the command about to be issued.
    always_comb begin
        case (cmd_i)
            CMD_PRE: addr_d = AP_MASK;
            CMD_LMR: addr_d = MODE_WORD;
            default: addr_d = '0;
        endcase
    end

    // Pin register: inhibit during reset, otherwise the selected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= CMD_INH;
            addr_o <= '0;
            ba_o   <= 2'b00;
        end else begin
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= cmd_i;
            addr_o <= addr_d;
            ba_o   <= 2'b00;
        end
    end

    // Clock enable and byte masks held high throughout.
    always_ff @(posedge clk) begin
        cke_o <= 1'b1;
        dqm_o <= '1;
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
// SDRAM power-up initialization sequencer, top level.
// Runs wait, all-bank precharge, N auto refreshes and a mode write, then raises
// init_done and drives NOP until reset. Timing parameters are in ps/ns and are
// rounded up to whole cycles. Assumes clk is the SDRAM clock and already stable.
module sdram_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int WAIT_NS       = 200000,
    parameter int TRP_NS        = 18,
    parameter int TRFC_NS       = 66,
    parameter int TMRD_CYC      = 2,
    parameter int REFRESH_COUNT = 8,
    parameter int DQ_WIDTH      = 16,
    parameter int ROW_BITS      = 13,
    parameter int AP_BIT        = 10,
    parameter logic [ROW_BITS-1:0] MODE_WORD = 'h033
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  sdr_cs_n,
    output logic                  sdr_ras_n,
    output logic                  sdr_cas_n,
    output logic                  sdr_we_n,
    output logic                  sdr_cke,
    output logic [DQ_WIDTH/8-1:0] sdr_dqm,
    output logic [1:0]            sdr_ba,
    output logic [ROW_BITS-1:0]   sdr_addr,
    output logic                  init_done
);

    localparam int DQM_W    = DQ_WIDTH / 8;
    localparam int WAIT_CYC = ps_to_cycles(WAIT_NS * 1000, CLK_PERIOD_PS);
    localparam int TRP_C    = ps_to_cycles(TRP_NS * 1000, CLK_PERIOD_PS);
    localparam int TRFC_C   = ps_to_cycles(TRFC_NS * 1000, CLK_PERIOD_PS);
    localparam int TMRD_C   = (TMRD_CYC < 1) ? 1 : TMRD_CYC;
    localparam int REF_N    = (REFRESH_COUNT < 8) ? 8 : REFRESH_COUNT;
    localparam int MAX_A    = (WAIT_CYC > TRP_C) ? WAIT_CYC : TRP_C;
    localparam int MAX_B    = (TRFC_C > TMRD_C) ? TRFC_C : TMRD_C;
    localparam int MAXV     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW       = $clog2(MAXV + 1);
    localparam int RW       = $clog2(REF_N + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    sdr_cmd_e      next_cmd;

    pwrup_timer #(
        .WIDTH     (TW),
        .RESET_VAL (TW'(WAIT_CYC - 1))
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pwrup_ctrl #(
        .TW     (TW),
        .REF_N  (REF_N),
        .TRP_C  (TRP_C),
        .TRFC_C (TRFC_C),
        .TMRD_C (TMRD_C)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .zero_i     (tmr_zero),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .cmd_o      (next_cmd),
        .done_o     (init_done)
    );

    pwrup_cmd_out #(
        .ROW_BITS  (ROW_BITS),
        .AP_BIT    (AP_BIT),
        .DQM_W     (DQM_W),
        .MODE_WORD (MODE_WORD)
    ) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (next_cmd),
        .cs_n_o  (sdr_cs_n),
        .ras_n_o (sdr_ras_n),
        .cas_n_o (sdr_cas_n),
        .we_n_o  (sdr_we_n),
        .cke_o   (sdr_cke),
        .dqm_o   (sdr_dqm),
        .ba_o    (sdr_ba),
        .addr_o  (sdr_addr)
    );

    // ---- Checker state: counts observed at the pins since reset ----
    logic [3:0]    bus_cmd;
    logic [TW-1:0] gate_cnt;
    logic          pre_seen;
    logic [RW-1:0] ref_seen;

    assign bus_cmd = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};

    // Edges since reset, saturating at the wait length.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gate_cnt <= '0;
        else if (gate_cnt < TW'(WAIT_CYC)) gate_cnt <= gate_cnt + 1'b1;
    end

    // Precharge and refresh commands seen on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_seen <= 1'b0;
            ref_seen <= '0;
        end else begin
            if (bus_cmd == CMD_PRE) pre_seen <= 1'b1;
            if (bus_cmd == CMD_REF && ref_seen != RW'(REF_N)) ref_seen <= ref_seen + 1'b1;
        end
    end

    // R3
    wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdr_cs_n && bus_cmd != CMD_NOP) |-> (gate_cnt == TW'(WAIT_CYC)));

    // R5
    ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_REF) |-> pre_seen);

    // R6
    lmr_after_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_LMR) |-> (ref_seen == RW'(REF_N)));

    // R8
    done_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (bus_cmd == CMD_NOP));

endmodule

// File: tb/sdram_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: runs the full sequence and reset-abort variants, comparing the bus each cycle
// against a schedule computed from the parameters.
module sdram_pwrup_seq_tb_top;

    localparam int PER_PS  = 4000;
    localparam int WAIT_NS = 4000;
    localparam int TRP_NS  = 18;
    localparam int TRFC_NS = 66;
    localparam int TMRD    = 2;
    localparam int NREF    = 8;
    localparam logic [12:0] MODE = 13'h022;

    localparam int W      = (WAIT_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int TRPC   = (TRP_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int TRFCC  = (TRFC_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int PRE_K  = W + 1;
    localparam int REF0_K = PRE_K + TRPC;
    localparam int LMR_K  = REF0_K + NREF * TRFCC;
    localparam int DONE_K = LMR_K + TMRD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n, ras_n, cas_n, we_n, cke, done;
    logic [1:0]  dqm, ba;
    logic [12:0] addr;
    logic [3:0]  bus;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    assign bus = {cs_n, ras_n, cas_n, we_n};

    always #2 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_PERIOD_PS (PER_PS),
        .WAIT_NS       (WAIT_NS),
        .TRP_NS        (TRP_NS),
        .TRFC_NS       (TRFC_NS),
        .TMRD_CYC      (TMRD),
        .REFRESH_COUNT (NREF),
        .DQ_WIDTH      (16),
        .ROW_BITS      (13),
        .AP_BIT        (10),
        .MODE_WORD     (MODE)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdr_cs_n  (cs_n),
        .sdr_ras_n (ras_n),
        .sdr_cas_n (cas_n),
        .sdr_we_n  (we_n),
        .sdr_cke   (cke),
        .sdr_dqm   (dqm),
        .sdr_ba    (ba),
        .sdr_addr  (addr),
        .init_done (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One sequence: reset, then follow the schedule up to stop_k (0 = whole run).
    task automatic run_seq(input int stop_k, input string rst_tag);
        logic [3:0] exp_cmd;
        string      tag;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 / R9: reset state
        chk(cs_n == 1'b1, rst_tag, "cs_n in reset", cs_n, 1);
        chk(done == 1'b0, rst_tag, "init_done in reset", done, 0);
        chk(cke == 1'b1 && dqm == 2'b11, "R2", "cke/dqm in reset", {cke, dqm}, 7);
        rst_n = 1'b1;
        for (int k = 1; k <= DONE_K + 16; k++) begin
            @(negedge clk);
            if (stop_k != 0 && k > stop_k) break;
            exp_cmd = 4'b0111;
            tag = (k < PRE_K) ? "R3" : "R8";
            if (k == PRE_K) begin
                exp_cmd = 4'b0010; tag = "R4";
            end else if (k >= REF0_K && k < LMR_K && ((k - REF0_K) % TRFCC) == 0) begin
                exp_cmd = 4'b0001; tag = "R5";
            end else if (k == LMR_K) begin
                exp_cmd = 4'b0000; tag = "R6";
            end
            chk(bus == exp_cmd, tag, $sformatf("command at cycle %0d", k), bus, exp_cmd);
            if (k == PRE_K)
                chk(addr[10] == 1'b1 && ba == 2'b00, "R4", "all-bank bit/bank", {ba, addr}, 13'h0400);
            if (k == LMR_K)
                chk(addr == MODE && ba == 2'b00, "R6", "mode word/bank", {ba, addr}, MODE);
            chk(done == (k >= DONE_K), "R7", $sformatf("init_done at cycle %0d", k), done, (k >= DONE_K));
            chk(cke == 1'b1 && dqm == 2'b11, "R2", "cke/dqm", {cke, dqm}, 7);
        end
    endtask

    initial begin
        run_seq(0, "R1");
        run_seq(W / 2, "R1");                  // abort during the wait
        run_seq(0, "R9");                      // R9: full restart after mid-wait reset
        run_seq(REF0_K + 3 * TRFCC + 2, "R9"); // abort between refreshes
        run_seq(0, "R9");                      // R9: full restart after mid-refresh reset
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule